// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block is the acceptance core of an interrupt controller that serves 256 vectors. Three 256-bit vectors of state record which vectors are requested, which are being serviced by the processor, and whether each request was level or edge triggered. Two software registers sit beside them. One is an 8-bit task priority. The other is a 9-bit spurious register: bit 8 enables the controller and bits 7:0 hold the vector returned when an acknowledge is refused.

Vectors rank by number, and the highest set bit wins. Priority comparisons work on 16-vector classes, which are the upper four bits of a vector. The processor priority combines the task priority with the class of the highest vector in service. The controller raises its interrupt line when a pending vector's class is above that priority.

The processor acknowledges by pulsing `ack`. In the same cycle it reads the outcome from `ack_vec`, `ack_none` and `ack_level`. It retires the handler with an `eoi` pulse.

All request, acknowledge and write inputs are single-cycle strobes that the block always accepts, so no back-pressure exists. The acknowledge outcome is combinational from the current state and is valid only while `ack` is high. State changes at the next clock edge, and `irq` and `ppr` follow at once from the new state.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset the pending, in-service and trigger vectors are clear, the task priority is 0x00 and the spurious register is 0x0FF (bit 8 clear, so disabled); `irq` is low and `ppr` is 0x00.
- R2: An acknowledge that is taken returns the highest-numbered pending vector; with nothing pending, `ack_none` is 1 and `ack_vec` is 0.
- R3: A taken acknowledge clears that vector's pending bit and sets its in-service bit at the next clock edge; a request for a vector in the same cycle keeps its pending bit set.
- R4: A request with `req_level`=1 sets the vector's trigger bit and one with `req_level`=0 clears it; `ack_level` reports the trigger bit of the vector taken (0 when none is taken).
- R5: `ppr` equals the task priority when task priority bits 7:4 are at least the class of the highest in-service vector, otherwise that class followed by four zero bits; an empty in-service vector counts as class 0.
- R6: `irq` is 1 only when bit 8 of the spurious register is 1, some vector is pending, and either `ppr` is 0 or the highest pending vector's bits 7:4 exceed `ppr` bits 7:4.
- R7: When the task priority is non-zero and the highest pending vector is less than or equal to it, an acknowledge returns the spurious register bits 7:0 with `ack_none`=0 and `ack_level`=0, and leaves pending and in-service state unchanged.
- R8: While spurious register bit 8 is 0, an acknowledge returns `ack_none`=1 and changes no state; pending requests are still recorded and become visible once the bit is set.
- R9: An end-of-interrupt clears only the highest set in-service bit; with nothing in service it has no effect.
- R10: A write to the task priority or spurious register takes effect on `irq` and `ppr` in the cycle after the write edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe for vector `req_vec` |
| req_vec | input | 8 | Requested vector number |
| req_level | input | 1 | 1 = level-triggered request, 0 = edge |
| ack | input | 1 | Processor acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| spur_we | input | 1 | Spurious register write strobe |
| spur_wdata | input | 9 | Spurious register value; bit 8 enable, bits 7:0 spurious vector |
| irq | output | 1 | Interrupt pending line to the processor |
| ack_vec | output | 8 | Vector returned for the current acknowledge |
| ack_none | output | 1 | Acknowledge found no deliverable interrupt |
| ack_level | output | 1 | Trigger mode of the vector taken |
| ppr | output | 8 | Processor priority |

## Verification
The hardest situation to reach from the ports is an acknowledge that succeeds while the class in service already outranks the pending class. In that case `irq` is low, but the acknowledge still takes the vector because only the task priority gates it. The bench reaches it by stacking two acknowledges with the task priority at zero. The masked-spurious case is also hard to reach, because it needs a non-zero task priority at or above the pending vector. The bench sets it up by raising the task priority over a pending vector. It then lowers the priority to show that `irq` rises at once and that the refused vector was kept.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int CLS_LSB = 4;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_SPUR = 2'd1,
    ACK_TAKE = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/vpc_msb_find.sv
module vpc_msb_find #(
  parameter int W  = 256,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |bits;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vpc_prio_eval.sv
module vpc_prio_eval #(
  parameter int VW = 8,
  parameter int CW = VW - vpc_pkg::CLS_LSB
) (
  input  logic          enable,
  input  logic [VW-1:0] tpr,
  input  logic          isr_any,
  input  logic [CW-1:0] isr_cls,
  input  logic          irr_any,
  input  logic [CW-1:0] irr_cls,
  output logic [VW-1:0] ppr,
  output logic          irq
);
  localparam int LSB = vpc_pkg::CLS_LSB;

  logic [CW-1:0] svc_cls;

  always_comb begin
    svc_cls = isr_any ? isr_cls : '0;
    if (tpr[VW-1:LSB] >= svc_cls) ppr = tpr;
    else                          ppr = {svc_cls, {LSB{1'b0}}};
    irq = enable && irr_any &&
          ((ppr == '0) || (irr_cls > ppr[VW-1:LSB]));
  end
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl #(
  parameter int NVEC = 256,
  parameter int VW   = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [VW-1:0] req_vec,
  input  logic          req_level,
  input  logic          ack,
  input  logic          eoi,
  input  logic          tpr_we,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          spur_we,
  input  logic [VW:0]   spur_wdata,
  output logic          irq,
  output logic [VW-1:0] ack_vec,
  output logic          ack_none,
  output logic          ack_level,
  output logic [VW-1:0] ppr
);
  import vpc_pkg::*;

  localparam int CW = VW - CLS_LSB;
  localparam logic [VW:0] SPUR_RST = {1'b0, {VW{1'b1}}};

  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  logic [NVEC-1:0] irr_n, isr_n, tmr_n;
  logic [VW-1:0]   tpr_q;
  logic [VW:0]     spur_q;

  logic            irr_any, isr_any;
  logic [VW-1:0]   irr_top, isr_top;
  ack_kind_e       ack_kind;

  vpc_msb_find #(.W(NVEC), .IW(VW)) u_irr_find (
    .bits(irr_q), .any(irr_any), .idx(irr_top)
  );

  vpc_msb_find #(.W(NVEC), .IW(VW)) u_isr_find (
    .bits(isr_q), .any(isr_any), .idx(isr_top)
  );

  vpc_prio_eval #(.VW(VW), .CW(CW)) u_prio (
    .enable  (spur_q[VW]),
    .tpr     (tpr_q),
    .isr_any (isr_any),
    .isr_cls (isr_top[VW-1:CLS_LSB]),
    .irr_any (irr_any),
    .irr_cls (irr_top[VW-1:CLS_LSB]),
    .ppr     (ppr),
    .irq     (irq)
  );

  always_comb begin
    if (!spur_q[VW] || !irr_any)                          ack_kind = ACK_NONE;
    else if ((tpr_q != '0) && (irr_top <= tpr_q))         ack_kind = ACK_SPUR;
    else                                                  ack_kind = ACK_TAKE;
  end

  always_comb begin
    ack_none  = (ack_kind == ACK_NONE);
    ack_vec   = '0;
    ack_level = 1'b0;
    case (ack_kind)
      ACK_SPUR: ack_vec = spur_q[VW-1:0];
      ACK_TAKE: begin
        ack_vec   = irr_top;
        ack_level = tmr_q[irr_top];
      end
      default: ;
    endcase
  end

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (eoi && isr_any) isr_n[isr_top] = 1'b0;
    if (ack && ack_kind == ACK_TAKE) begin
      irr_n[irr_top] = 1'b0;
      isr_n[irr_top] = 1'b1;
    end
    if (req_valid) begin
      irr_n[req_vec] = 1'b1;
      tmr_n[req_vec] = req_level;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      tmr_q  <= '0;
      tpr_q  <= '0;
      spur_q <= SPUR_RST;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
      if (tpr_we)  tpr_q  <= tpr_wdata;
      if (spur_we) spur_q <= spur_wdata;
    end
  end
endmodule

// File: rtl/vpc_chk.sv
module vpc_chk #(
  parameter int NVEC = 256,
  parameter int VW   = $clog2(NVEC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VW-1:0]   req_vec,
  input logic            req_level,
  input logic            ack,
  input logic            eoi,
  input logic            irq,
  input logic [VW-1:0]   ack_vec,
  input logic            ack_none,
  input logic [VW-1:0]   ppr,
  input logic [VW-1:0]   tpr_q,
  input logic [VW:0]     spur_q,
  input logic [NVEC-1:0] irr_q,
  input logic [NVEC-1:0] isr_q,
  input logic [NVEC-1:0] tmr_q
);
  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (spur_q[VW] && irr_q != '0));

  // R5
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_q);

  // R8
  disabled_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !spur_q[VW]) |-> ack_none);

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_none && !eoi) |=> $stable(isr_q));

  // R4
  level_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_level) |=> tmr_q[$past(req_vec)]);

  // R3
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_none) |=>
      (isr_q[$past(ack_vec)] || ($past(ack_vec) == $past(spur_q[VW-1:0]))));

  // R9
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && isr_q == '0) |=> (isr_q == '0));
endmodule

bind vec_prio_ctrl vpc_chk #(.NVEC(NVEC), .VW(VW)) u_vpc_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
  .req_level(req_level), .ack(ack), .eoi(eoi), .irq(irq), .ack_vec(ack_vec),
  .ack_none(ack_none), .ppr(ppr), .tpr_q(tpr_q), .spur_q(spur_q),
  .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q)
);

// File: tb/test_vec_prio_ctrl.sv
module test_vec_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_vec = '0;
  logic       req_level = 1'b0;
  logic       ack = 1'b0;
  logic       eoi = 1'b0;
  logic       tpr_we = 1'b0;
  logic [7:0] tpr_wdata = '0;
  logic       spur_we = 1'b0;
  logic [8:0] spur_wdata = '0;
  logic       irq;
  logic [7:0] ack_vec;
  logic       ack_none;
  logic       ack_level;
  logic [7:0] ppr;

  int total = 0;
  int bad = 0;

  vec_prio_ctrl i_vec_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .req_level(req_level), .ack(ack), .eoi(eoi), .tpr_we(tpr_we),
    .tpr_wdata(tpr_wdata), .spur_we(spur_we), .spur_wdata(spur_wdata),
    .irq(irq), .ack_vec(ack_vec), .ack_none(ack_none),
    .ack_level(ack_level), .ppr(ppr)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send_req(input logic [7:0] v, input logic lvl);
    @(negedge clk);
    req_valid = 1'b1; req_vec = v; req_level = lvl;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  task automatic do_ack(output int v, output int none, output int lvl);
    @(negedge clk);
    ack = 1'b1;
    #1;
    v = ack_vec; none = ack_none; lvl = ack_level;
    @(negedge clk);
    ack = 1'b0;
    #1;
  endtask

  task automatic do_eoi;
    @(negedge clk);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    #1;
  endtask

  task automatic wr_tpr(input logic [7:0] d);
    @(negedge clk);
    tpr_we = 1'b1; tpr_wdata = d;
    @(negedge clk);
    tpr_we = 1'b0;
    #1;
  endtask

  task automatic wr_spur(input logic [8:0] d);
    @(negedge clk);
    spur_we = 1'b1; spur_wdata = d;
    @(negedge clk);
    spur_we = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    int v, n, l;
    check("R1", "irq after reset", irq, 0);
    check("R1", "ppr after reset", ppr, 0);
    do_ack(v, n, l);
    check("R8", "ack none while disabled", n, 1);
    check("R1", "ack_vec while disabled", v, 0);
  endtask

  task automatic t_basic_order;
    int v, n, l;
    wr_spur(9'h10F);
    do_ack(v, n, l);
    check("R2", "ack none when empty", n, 1);
    send_req(8'h35, 1'b0);
    send_req(8'h82, 1'b1);
    send_req(8'h20, 1'b0);
    check("R6", "irq with pending and ppr 0", irq, 1);
    do_ack(v, n, l);
    check("R2", "highest vector taken", v, 8'h82);
    check("R4", "level trigger reported", l, 1);
    check("R5", "ppr from in-service class", ppr, 8'h80);
    check("R6", "irq low when class not above ppr", irq, 0);
    do_ack(v, n, l);
    check("R3", "next vector after move", v, 8'h35);
    check("R4", "edge trigger reported", l, 0);
    check("R5", "ppr keeps highest in-service", ppr, 8'h80);
    do_eoi();
    check("R9", "eoi clears highest in-service", ppr, 8'h30);
    check("R6", "irq again with ppr 0x30 vs 0x20", irq, 0);
    do_eoi();
    check("R9", "second eoi empties in-service", ppr, 8'h00);
    check("R6", "irq with ppr back to zero", irq, 1);
    do_ack(v, n, l);
    check("R2", "last pending vector", v, 8'h20);
    do_eoi();
    do_eoi();
    check("R9", "eoi on empty leaves ppr", ppr, 8'h00);
    do_ack(v, n, l);
    check("R3", "pending emptied by acks", n, 1);
  endtask

  task automatic t_task_prio;
    int v, n, l;
    wr_tpr(8'h50);
    check("R10", "ppr follows tpr write", ppr, 8'h50);
    send_req(8'h45, 1'b0);
    check("R6", "irq masked by tpr class", irq, 0);
    do_ack(v, n, l);
    check("R7", "spurious vector returned", v, 8'h0F);
    check("R7", "spurious not none", n, 0);
    check("R7", "spurious level 0", l, 0);
    check("R7", "ppr unchanged by spurious", ppr, 8'h50);
    wr_tpr(8'h30);
    check("R10", "irq rises at once on tpr lowering", irq, 1);
    check("R7", "pending kept after spurious", irq, 1);
    do_ack(v, n, l);
    check("R2", "vector above tpr taken", v, 8'h45);
    check("R5", "ppr uses in-service class", ppr, 8'h40);
    wr_tpr(8'h5A);
    check("R5", "ppr uses tpr when its class is higher", ppr, 8'h5A);
    do_eoi();
    wr_tpr(8'h00);
    check("R9", "eoi released class 4", ppr, 8'h00);
  endtask

  task automatic t_retrigger;
    int v, n, l;
    send_req(8'h90, 1'b1);
    send_req(8'h90, 1'b0);
    do_ack(v, n, l);
    check("R4", "edge request clears trigger bit", l, 0);
    check("R2", "retriggered vector", v, 8'h90);
    do_eoi();
  endtask

  task automatic t_same_cycle;
    int v, n, l;
    send_req(8'h61, 1'b0);
    @(negedge clk);
    ack = 1'b1; req_valid = 1'b1; req_vec = 8'h61; req_level = 1'b1;
    #1;
    check("R2", "ack with request same cycle", ack_vec, 8'h61);
    @(negedge clk);
    ack = 1'b0; req_valid = 1'b0;
    #1;
    check("R5", "ppr after same-cycle take", ppr, 8'h60);
    do_eoi();
    do_ack(v, n, l);
    check("R3", "request kept pending over same-cycle ack", v, 8'h61);
    check("R4", "new trigger bit kept", l, 1);
    do_eoi();
  endtask

  task automatic t_disable;
    int v, n, l;
    wr_spur(9'h0AA);
    send_req(8'h10, 1'b0);
    check("R6", "irq low when disabled", irq, 0);
    do_ack(v, n, l);
    check("R8", "ack none when disabled", n, 1);
    wr_spur(9'h1AA);
    check("R10", "irq after enabling", irq, 1);
    do_ack(v, n, l);
    check("R8", "request kept while disabled", v, 8'h10);
    do_eoi();
  endtask

  task automatic t_edges;
    int v, n, l;
    send_req(8'h00, 1'b0);
    check("R6", "vector 0 raises irq at ppr 0", irq, 1);
    do_ack(v, n, l);
    check("R2", "vector 0 taken", v, 8'h00);
    check("R2", "vector 0 not none", n, 0);
    send_req(8'hFF, 1'b1);
    check("R6", "vector 0xFF above class 0", irq, 1);
    do_ack(v, n, l);
    check("R2", "vector 0xFF taken", v, 8'hFF);
    check("R5", "ppr at top class", ppr, 8'hF0);
    do_eoi();
    check("R9", "eoi clears 0xFF leaving 0", ppr, 8'h00);
    do_eoi();
    check("R6", "irq idle at end", irq, 0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_basic_order();
    t_task_prio();
    t_retrigger();
    t_same_cycle();
    t_disable();
    t_edges();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule